// File: doc/BRIEF.md
# Burst SRAM Core with Zero-Turnaround Pipeline

This block is a synthesizable single-port synchronous SRAM model for simulation. Each word holds 18 bits, split into two 9-bit lanes, and each lane is one data byte plus its parity bit. All control is sampled on the rising clock edge. The data phase of an access is the clock period that follows the edge that captured its address. Read data drives out during that period. Write data is captured at the next recognized edge. Because of this, a read can follow a write, and a write can follow a read, with no idle cycle between them.

An access starts with a load. The load captures the address, the access type (read or write) and the burst order. Advance cycles that follow step a two-bit beat counter over the two low address bits. The upper address bits stay fixed. The burst order is either linear or interleaved. A freeze input stalls the whole pipeline, and three select pins decide whether a load starts an access or deselects the block. The read path has a separate drive-enable output that stands in for a tri-state pad.

Top module: `burst_sram`

## Requirements
- R1: While reset is held and right after it is released, `dout_en` is 0 and no burst is active.
- R2: A load (`advance`=0) starts an access only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other select combination deselects the block, and `dout_en` is 0 in the following cycle.
- R3: When a read is loaded at a recognized edge, `dout` shows the stored word in the cycle after that edge. `dout_en` is 1 in that cycle when `out_en_n` is 0.
- R4: Write data is taken from `din` at the first recognized edge after the write's address edge. Lane i occupies bits [9i+8:9i] (lane 0 is bits 8:0, lane 1 is bits 17:9, with the parity bit at the top of each lane). Lane i is written only when `lane_wr_n[i]` was 0 at the address edge.
- R5: When `order_ilv` is 0 at the load, the low two address bits of successive beats are start, start+1, start+2, start+3 (modulo 4). The upper address bits stay fixed.
- R6: When `order_ilv` is 1 at the load, the low two address bits of beat k are start XOR k, for k = 0 to 3.
- R7: `write_n` is sampled only at a load. Advance cycles keep the access type of their burst.
- R8: An advance continues an active burst whatever the select pins show.
- R9: After a deselect, advance cycles perform no access and write nothing until a new selected load.
- R10: While `freeze` is 1, a clock edge changes no state and commits no write. The current phase, including its output, carries on.
- R11: `dout_en` is 0 during a write's data phase, and also during a read's data phase while `out_en_n` is 1.
- R12: A write followed immediately by a read of the same address returns the new data, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| freeze | input | 1 | 1 = ignore this clock edge entirely |
| advance | input | 1 | 0 = load a new address and type, 1 = step the burst |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| write_n | input | 1 | 0 = write access (sampled at load) |
| lane_wr_n | input | 2 | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address (low two bits seed the burst) |
| order_ilv | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Output enable, active low, combinational |
| din | input | 18 | Write data, two 9-bit lanes |
| dout | output | 18 | Read data of the current phase |
| dout_en | output | 1 | 1 when `dout` is to be driven |

## Verification
Write bursts start from a non-zero low address. The same words are then read back with linear and with interleaved order. A swapped beat sequence, or a counter that ignores the order strap, shows up as a wrong word. Writes and reads alternate on the same address with no gap, which exposes any extra pipeline stage on the write commit. Partial lane writes separate the two lanes and their parity bits. Stalls during read and write phases, and advances following each kind of deselect, confirm that frozen or idle cycles neither move the burst nor store stray data.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  // Low two address bits for a given beat of the burst.
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input order_e     ord);
    logic [1:0] res;
    if (ord == ORD_XOR) res = start ^ beat;
    else                res = start + beat;
    return res;
  endfunction

endpackage

// File: rtl/burst_sram_seq.sv
module burst_sram_seq
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic              advance,
  input  logic              selected,
  input  logic              write_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              order_ilv,
  output logic              ph_live,
  output logic              ph_wr,
  output logic [LANES-1:0]  ph_lane_n,
  output logic [ADDR_W-1:0] ph_addr,
  output logic              ph_ilv
);

  localparam int HI_W = ADDR_W - 2;

  logic             active_q;
  logic             wr_q;
  logic [HI_W-1:0]  base_q;
  logic [1:0]       start_q;
  logic [1:0]       beat_q;
  order_e           ord_q;
  logic             live_q;
  logic [LANES-1:0] lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      base_q   <= '0;
      start_q  <= '0;
      beat_q   <= '0;
      ord_q    <= ORD_LINEAR;
      live_q   <= 1'b0;
      lane_q   <= '1;
    end else if (!freeze) begin
      if (!advance) begin
        if (selected) begin
          active_q <= 1'b1;
          wr_q     <= ~write_n;
          base_q   <= addr[ADDR_W-1:2];
          start_q  <= addr[1:0];
          beat_q   <= 2'd0;
          ord_q    <= order_e'(order_ilv);
          live_q   <= 1'b1;
          lane_q   <= lane_wr_n;
        end else begin
          active_q <= 1'b0;
          live_q   <= 1'b0;
        end
      end else if (active_q) begin
        beat_q <= beat_q + 2'd1;
        live_q <= 1'b1;
        lane_q <= lane_wr_n;
      end else begin
        live_q <= 1'b0;
      end
    end
  end

  assign ph_live   = live_q;
  assign ph_wr     = wr_q;
  assign ph_lane_n = lane_q;
  assign ph_ilv    = (ord_q == ORD_XOR);
  assign ph_addr   = {base_q, beat_offset(start_q, beat_q, ord_q)};

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    freeze,
  input  logic                    commit,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (!freeze && commit && !lane_wr_n[g])
        mem[addr] <= din[g*LANE_W +: LANE_W];
    end

    assign dout[g*LANE_W +: LANE_W] = mem[addr];
  end

endmodule

// File: rtl/burst_sram_drive.sv
module burst_sram_drive (
  input  logic ph_live,
  input  logic ph_wr,
  input  logic out_en_n,
  output logic dout_en
);

  // Drive only in a live read phase with output enable low.
  assign dout_en = ph_live & ~ph_wr & ~out_en_n;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    freeze,
  input  logic                    advance,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    write_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    order_ilv,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);

  logic              selected;
  logic              ph_live;
  logic              ph_wr;
  logic              ph_ilv;
  logic [LANES-1:0]  ph_lane_n;
  logic [ADDR_W-1:0] ph_addr;

  assign selected = ~sel_a_n & sel_b & ~sel_c_n;

  burst_sram_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze    (freeze),
    .advance   (advance),
    .selected  (selected),
    .write_n   (write_n),
    .lane_wr_n (lane_wr_n),
    .addr      (addr),
    .order_ilv (order_ilv),
    .ph_live   (ph_live),
    .ph_wr     (ph_wr),
    .ph_lane_n (ph_lane_n),
    .ph_addr   (ph_addr),
    .ph_ilv    (ph_ilv)
  );

  burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk       (clk),
    .freeze    (freeze),
    .commit    (ph_live & ph_wr),
    .lane_wr_n (ph_lane_n),
    .addr      (ph_addr),
    .din       (din),
    .dout      (dout)
  );

  burst_sram_drive u_drive (
    .ph_live  (ph_live),
    .ph_wr    (ph_wr),
    .out_en_n (out_en_n),
    .dout_en  (dout_en)
  );

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              freeze,
  input logic              advance,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              write_n,
  input logic              out_en_n,
  input logic              dout_en,
  input logic              ph_live,
  input logic              ph_wr,
  input logic              ph_ilv,
  input logic [ADDR_W-1:0] ph_addr
);

  logic pins_sel;
  assign pins_sel = ~sel_a_n & sel_b & ~sel_c_n;

  p_desel_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !advance && !pins_sel) |=> !dout_en);

  p_read_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !advance && pins_sel && write_n) |=> (dout_en || out_en_n));

  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && advance && ph_live) |=>
      (ph_addr[ADDR_W-1:2] == $past(ph_addr[ADDR_W-1:2])));

  p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && advance && ph_live && !ph_ilv) |=>
      (ph_addr[1:0] == $past(ph_addr[1:0]) + 2'd1));

  p_type_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && advance) |=> $stable(ph_wr));

  p_adv_any_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && advance && ph_live) |=> ph_live);

  p_idle_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && advance && !ph_live) |=> !ph_live);

  p_freeze_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(ph_addr) && $stable(ph_live) && $stable(ph_wr)));

  p_write_float_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !advance && pins_sel && !write_n) |=> !dout_en);

endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .freeze   (freeze),
  .advance  (advance),
  .sel_a_n  (sel_a_n),
  .sel_b    (sel_b),
  .sel_c_n  (sel_c_n),
  .write_n  (write_n),
  .out_en_n (out_en_n),
  .dout_en  (dout_en),
  .ph_live  (ph_live),
  .ph_wr    (ph_wr),
  .ph_ilv   (ph_ilv),
  .ph_addr  (ph_addr)
);

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;

  localparam logic [2:0] SEL = 3'b010; // {sel_a_n, sel_b, sel_c_n}
  localparam logic [17:0] D0 = 18'h1A5C3, D1 = 18'h2B6D4,
                          D2 = 18'h0C7E5, D3 = 18'h3D8F6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        freeze = 1'b0;
  logic        advance = 1'b0;
  logic        sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic        write_n = 1'b1;
  logic [1:0]  lane_wr_n = 2'b11;
  logic [7:0]  addr = '0;
  logic        order_ilv = 1'b0;
  logic        out_en_n = 1'b0;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic        dout_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic        eoe;
    logic [17:0] ed;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  burst_sram dut_i (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .advance(advance),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .write_n(write_n), .lane_wr_n(lane_wr_n), .addr(addr),
    .order_ilv(order_ilv), .out_en_n(out_en_n), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  // Driver: one recognized (or frozen) edge per call; expectation is the
  // output in the cycle after that edge.
  task automatic go(input logic adv, input logic [2:0] ce, input logic wr_n,
                    input logic [1:0] ln, input logic [7:0] a, input logic ilv,
                    input logic oen, input logic frz, input logic [17:0] wd,
                    input logic eoe, input logic [17:0] ed, input string tag);
    exp_t e;
    @(negedge clk); #1;
    advance = adv; {sel_a_n, sel_b, sel_c_n} = ce; write_n = wr_n;
    lane_wr_n = ln; addr = a; order_ilv = ilv; out_en_n = oen;
    freeze = frz; din = wd;
    e.eoe = eoe; e.ed = ed; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compares at the falling edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (dout_en !== e.eoe || (e.eoe && dout !== e.ed)) begin
        errors++;
        $display("FAIL %s dout_en=%0b exp=%0b dout=%h exp=%h",
                 e.tag, dout_en, e.eoe, dout, e.ed);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (dout_en !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset dout_en=%0b exp=0", dout_en);
    end

    // adv ce wr ln addr ilv oen frz din eoe exp tag
    go(0, 3'b110, 1, 2'b11, 8'h00, 0, 0, 0, 18'h0, 0, 18'h0, "R2 idle");
    // Linear write burst from 0x12: 12,13,10,11 ; write_n high on advances (R7)
    go(0, SEL, 0, 2'b00, 8'h12, 0, 0, 0, 18'h0, 0, 18'h0, "R11 write phase");
    go(1, SEL, 1, 2'b00, 8'h00, 0, 0, 0, D0, 0, 18'h0, "R7 R11 write beat1");
    go(1, SEL, 1, 2'b00, 8'h00, 0, 0, 0, D1, 0, 18'h0, "R7 write beat2");
    go(1, SEL, 1, 2'b00, 8'h00, 0, 0, 0, D2, 0, 18'h0, "R7 write beat3");
    // Linear read from 0x10: 10,11,12,13,10
    go(0, SEL, 1, 2'b11, 8'h10, 0, 0, 0, D3, 1, D2, "R3 R5 beat0");
    go(1, SEL, 1, 2'b11, 8'h00, 0, 0, 0, 18'h0, 1, D3, "R5 R12 beat1");
    go(1, SEL, 1, 2'b11, 8'h00, 0, 0, 0, 18'h0, 1, D0, "R5 beat2");
    go(1, SEL, 1, 2'b11, 8'h00, 0, 0, 0, 18'h0, 1, D1, "R5 beat3");
    go(1, SEL, 1, 2'b11, 8'h00, 0, 0, 0, 18'h0, 1, D2, "R5 wrap");
    // Interleaved read from 0x11: 11,10,13,12
    go(0, SEL, 1, 2'b11, 8'h11, 1, 0, 0, 18'h0, 1, D3, "R6 beat0");
    go(1, SEL, 1, 2'b11, 8'h00, 0, 0, 0, 18'h0, 1, D2, "R6 beat1");
    go(1, SEL, 1, 2'b11, 8'h00, 0, 0, 0, 18'h0, 1, D1, "R6 beat2");
    go(1, SEL, 1, 2'b11, 8'h00, 0, 0, 0, 18'h0, 1, D0, "R6 beat3");
    // R7: write_n low on an advance of a read burst
    go(0, SEL, 1, 2'b11, 8'h10, 0, 0, 0, 18'h0, 1, D2, "R7 load read");
    go(1, SEL, 0, 2'b00, 8'h00, 0, 0, 0, 18'h0, 1, D3, "R7 stays read");
    // R8: advance with pins deselected
    go(0, SEL, 1, 2'b11, 8'h12, 0, 0, 0, 18'h0, 1, D0, "R8 load");
    go(1, 3'b111, 1, 2'b11, 8'h00, 0, 0, 0, 18'h0, 1, D1, "R8 advance desel pins");
    // R12: write then read same address, no gap
    go(0, SEL, 0, 2'b00, 8'h20, 0, 0, 0, 18'h0, 0, 18'h0, "R12 write");
    go(0, SEL, 1, 2'b11, 8'h20, 0, 0, 0, 18'h15555, 1, 18'h15555, "R12 read back");
    // R4: lane writes at 0x30
    go(0, SEL, 0, 2'b00, 8'h30, 0, 0, 0, 18'h0, 0, 18'h0, "R4 full write");
    go(0, SEL, 0, 2'b10, 8'h30, 0, 0, 0, 18'h3FFFF, 0, 18'h0, "R4 lane0 write");
    go(0, SEL, 0, 2'b11, 8'h30, 0, 0, 0, 18'h0, 0, 18'h0, "R4 no-lane write");
    go(0, SEL, 1, 2'b11, 8'h30, 0, 0, 0, 18'h0, 1, 18'h3FE00, "R4 lane0 only");
    go(0, SEL, 0, 2'b01, 8'h30, 0, 0, 0, 18'h0, 0, 18'h0, "R4 lane1 write");
    go(0, SEL, 1, 2'b11, 8'h30, 0, 0, 0, 18'h0A5FF, 1, 18'h0A400, "R4 lane1 only");
    // R11: output enable high on a read
    go(0, SEL, 1, 2'b11, 8'h30, 0, 1, 0, 18'h0, 0, 18'h0, "R11 out_en_n high");
    // R9 / R2: write 0x35 and 0x34, then deselect variants, then advances
    go(0, SEL, 0, 2'b00, 8'h35, 0, 0, 0, 18'h0, 0, 18'h0, "R9 prep");
    go(0, SEL, 0, 2'b00, 8'h34, 0, 0, 0, 18'h22222, 0, 18'h0, "R9 prep2");
    go(0, 3'b110, 1, 2'b11, 8'h00, 0, 0, 0, 18'h11111, 0, 18'h0, "R2 sel_a_n high");
    go(0, 3'b000, 1, 2'b11, 8'h00, 0, 0, 0, 18'h0, 0, 18'h0, "R2 sel_b low");
    go(0, 3'b011, 1, 2'b11, 8'h00, 0, 0, 0, 18'h0, 0, 18'h0, "R2 sel_c_n high");
    go(1, SEL, 0, 2'b00, 8'h00, 0, 0, 0, 18'h0, 0, 18'h0, "R9 adv idle");
    go(1, SEL, 0, 2'b00, 8'h00, 0, 0, 0, 18'h3FFFF, 0, 18'h0, "R9 adv idle2");
    go(0, SEL, 1, 2'b11, 8'h34, 0, 0, 0, 18'h3FFFF, 1, 18'h11111, "R9 0x34 intact");
    go(1, SEL, 1, 2'b11, 8'h00, 0, 0, 0, 18'h0, 1, 18'h22222, "R9 0x35 intact");
    // R10: freeze during read and during write data phase
    go(0, SEL, 1, 2'b11, 8'h10, 0, 0, 0, 18'h0, 1, D2, "R10 pre");
    go(1, SEL, 1, 2'b11, 8'h00, 0, 0, 1, 18'h0, 1, D2, "R10 frozen read");
    go(1, SEL, 1, 2'b11, 8'h00, 0, 0, 0, 18'h0, 1, D3, "R10 resume");
    go(0, SEL, 0, 2'b00, 8'h40, 0, 0, 0, 18'h0, 0, 18'h0, "R10 write");
    go(0, SEL, 1, 2'b11, 8'h40, 0, 0, 1, 18'h0F0F0, 0, 18'h0, "R10 frozen write");
    go(0, SEL, 1, 2'b11, 8'h40, 0, 0, 0, 18'h30303, 1, 18'h30303, "R10 after stall");

    repeat (3) @(negedge clk);
    // R1: reset in the middle of a live read phase
    rst_n = 1'b0;
    #1;
    checks++;
    if (dout_en !== 1'b0) begin
      errors++;
      $display("FAIL R1 mid-run reset dout_en=%0b exp=0", dout_en);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule